// File: doc/BRIEF.md
# Limit-Compare Timer with Dual Modes

This block is a small memory-mapped timer. A word-indexed register bus with separate read and write strobes and 32-bit data reaches five registers. A tick-enable input pulses once per counter period, nominally every 500 ns. The block spends most of each period idle, and all of its state advances only on that pulse.

In system mode, a counter runs up to a programmable limit and wraps. Each wrap sets a sticky reached flag, and the flag drives the interrupt output. Software acknowledges the interrupt by reading the limit register. That read also clears the flag and restarts the count. In user mode, a wide free-running accumulator counts ticks instead. Software can stop and resume it, and reads it as two words; reading the low word freezes a copy of the high word, so the two halves match. User mode never raises the interrupt. A parameter fixes an instance as a system-only timer.

The counter value is placed at register bit `SHIFT` and above, and the bits below always read as zero. With the default `SHIFT` of 9, the count occupies bits 30..9, which makes it a 22-bit tick counter and a 54-bit user accumulator.

Top module: `cmp_timer`

## Requirements
- R1: After reset the limit is 0, the count is 0, the reached flag and `irq` are low, the user counter is stopped (offset 3 reads 1) and the mode is system (offset 4 reads 0).
- R2: A limit write (offset 0 or 2) of value 0 stores 0x7FFFFFFF; any other value stores its bits 30..0 and drops bit 31. In system mode, offset 0 reads back the stored limit.
- R3: In system mode, offset 1 reads {reached, count, zeros}: bit 31 holds the reached flag, the count sits at bits 30..SHIFT, and bits SHIFT-1..0 are zero. The count rises by one per tick pulse.
- R4: The period P is limit[30:SHIFT], or 2^(31-SHIFT) when that field is 0. On a tick where count+1 >= P, the count becomes 0 and the reached flag sets. This includes a count already above a newly written P.
- R5: A write to offset 0 loads the limit and restarts the count at 0. A write to offset 2 loads the limit and leaves the count unchanged.
- R6: In system mode, a read of offset 0 returns the limit, and in the same step clears the reached flag, drops `irq` and restarts the count at 0.
- R7: The reached flag and `irq` stay set across further ticks and offset 1 reads until the acknowledge of R6.
- R8: In user mode, a running accumulator rises by one per tick. An offset 1 read returns {0, acc[31-SHIFT-1:0], zeros} and latches acc bits 30+CNT_W..CNT_W. An offset 0 read returns {0, latched bits}, where CNT_W = 31-SHIFT.
- R9: In user mode, writing offset 3 with bit 0 = 1 stops the accumulator, and writing it with bit 0 = 0 resumes it with its count kept. Offset 3 reads {31'b0, stopped}. In system mode, offset 3 writes are ignored.
- R10: In user mode, `irq` is low and the system count and reached flag do not change. On return to system mode, both resume with their held values.
- R11: Offset 4 bit 0 selects user (1) or system (0) mode and reads back as {31'b0, mode}. When `FIXED_SYSTEM` is 1, writes to offset 4 are ignored and the mode stays system.
- R12: A read of offset 2, 5, 6 or 7 returns 0. Writes to offsets 5..7 change no state.
- R13: `rdata` is registered. It updates in the cycle after `rd_en`, carries the value from before that read's side effects, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per counter period |
| reg_addr | input | 3 | Word offset (byte address bits 4..2) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, high while reached is set in system mode |

## Verification
The bench builds two instances with `SHIFT` set to 27, so the count field is 4 bits wide and the user accumulator is 36 bits. With that setting, the full 16-tick period and the carry from the low user word into the latched high word are reached in a few dozen ticks instead of millions. One instance can switch modes. The second has `FIXED_SYSTEM` set to 1 and shares its bus with the first, so that a mode write it must ignore can be checked.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    typedef enum logic [2:0] {
        SEL_LIMIT   = 3'd0,
        SEL_COUNT   = 3'd1,
        SEL_LIM_KEEP = 3'd2,
        SEL_RUNCTL  = 3'd3,
        SEL_MODE    = 3'd4,
        SEL_RSV5    = 3'd5,
        SEL_RSV6    = 3'd6,
        SEL_RSV7    = 3'd7
    } sel_e;

    typedef enum logic {
        MODE_SYS  = 1'b0,
        MODE_USER = 1'b1
    } mode_e;

    typedef struct packed {
        logic        load_limit;
        logic        restart;
        logic        ack;
        logic [30:0] limit_val;
    } sys_ctl_t;

    typedef struct packed {
        logic stop_req;
        logic run_req;
        logic snap;
    } usr_ctl_t;

    function automatic logic [30:0] fix_limit(input logic [31:0] v);
        return (v == 32'd0) ? 31'h7FFF_FFFF : v[30:0];
    endfunction

endpackage

// File: rtl/cmp_timer_decode.sv
module cmp_timer_decode
    import cmp_timer_pkg::*;
#(
    parameter bit FIXED_SYSTEM = 1'b0
) (
    input  sel_e        sel,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] wdata,
    input  mode_e       mode,
    output sys_ctl_t    sys_ctl,
    output usr_ctl_t    usr_ctl,
    output logic        mode_we
);

    logic is_user;
    assign is_user = (mode == MODE_USER);

    always_comb begin
        sys_ctl.load_limit = wr_en && (sel == SEL_LIMIT || sel == SEL_LIM_KEEP);
        sys_ctl.limit_val  = fix_limit(wdata);
        sys_ctl.ack        = rd_en && (sel == SEL_LIMIT) && !is_user;
        sys_ctl.restart    = (wr_en && sel == SEL_LIMIT) || sys_ctl.ack;

        usr_ctl.stop_req   = wr_en && (sel == SEL_RUNCTL) && is_user && wdata[0];
        usr_ctl.run_req    = wr_en && (sel == SEL_RUNCTL) && is_user && !wdata[0];
        usr_ctl.snap       = rd_en && (sel == SEL_COUNT) && is_user;
    end

    generate
        if (FIXED_SYSTEM) begin : g_fixed
            assign mode_we = 1'b0;
        end else begin : g_switch
            assign mode_we = wr_en && (sel == SEL_MODE);
        end
    endgenerate

endmodule

// File: rtl/cmp_timer_sys.sv
module cmp_timer_sys
    import cmp_timer_pkg::*;
#(
    parameter int SHIFT = 9,
    parameter int CNT_W = 31 - SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             active,
    input  sys_ctl_t         ctl,
    output logic [30:0]      limit_q,
    output logic [CNT_W-1:0] count_q,
    output logic             reached_q
);

    localparam logic [CNT_W:0] FULL_PERIOD = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE         = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] lim_ticks;
    logic [CNT_W:0]   period;
    logic [CNT_W:0]   inc;
    logic             step;
    logic             wrap;

    always_comb begin
        lim_ticks = limit_q[30:SHIFT];
        period    = (lim_ticks == '0) ? FULL_PERIOD : {1'b0, lim_ticks};
        inc       = {1'b0, count_q} + ONE;
        step      = tick && active;
        wrap      = inc >= period;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q   <= '0;
            count_q   <= '0;
            reached_q <= 1'b0;
        end else begin
            if (ctl.load_limit)
                limit_q <= ctl.limit_val;

            if (ctl.restart)
                count_q <= '0;
            else if (step)
                count_q <= wrap ? '0 : inc[CNT_W-1:0];

            if (ctl.ack)
                reached_q <= 1'b0;
            else if (step && wrap && !ctl.restart)
                reached_q <= 1'b1;
        end
    end

endmodule

// File: rtl/cmp_timer_user.sv
module cmp_timer_user
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = 22,
    parameter int USER_W = CNT_W + 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              active,
    input  usr_ctl_t          ctl,
    output logic [USER_W-1:0] acc_q,
    output logic              stopped_q,
    output logic [30:0]       snap_q
);

    localparam logic [USER_W-1:0] ONE = {{(USER_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            stopped_q <= 1'b1;
            snap_q    <= '0;
        end else begin
            if (tick && active && !stopped_q)
                acc_q <= acc_q + ONE;

            if (ctl.stop_req)
                stopped_q <= 1'b1;
            else if (ctl.run_req)
                stopped_q <= 1'b0;

            if (ctl.snap)
                snap_q <= acc_q[CNT_W+30:CNT_W];
        end
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int SHIFT        = 9,
    parameter bit FIXED_SYSTEM = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [2:0]  reg_addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);

    localparam int CNT_W  = 31 - SHIFT;
    localparam int USER_W = CNT_W + 32;

    sel_e              sel;
    mode_e             mode_q;
    sys_ctl_t          sys_ctl;
    usr_ctl_t          usr_ctl;
    logic              mode_we;
    logic [30:0]       limit_q;
    logic [CNT_W-1:0]  sys_count;
    logic              reached;
    logic [USER_W-1:0] acc;
    logic              stopped;
    logic [30:0]       snap;
    logic [31:0]       rd_mux;
    logic [31:0]       rdata_q;
    logic              user_on;

    assign sel     = sel_e'(reg_addr);
    assign user_on = (mode_q == MODE_USER);

    cmp_timer_decode #(.FIXED_SYSTEM(FIXED_SYSTEM)) u_decode (
        .sel     (sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .mode    (mode_q),
        .sys_ctl (sys_ctl),
        .usr_ctl (usr_ctl),
        .mode_we (mode_we)
    );

    cmp_timer_sys #(.SHIFT(SHIFT), .CNT_W(CNT_W)) u_sys (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .active    (!user_on),
        .ctl       (sys_ctl),
        .limit_q   (limit_q),
        .count_q   (sys_count),
        .reached_q (reached)
    );

    cmp_timer_user #(.CNT_W(CNT_W), .USER_W(USER_W)) u_user (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .active    (user_on),
        .ctl       (usr_ctl),
        .acc_q     (acc),
        .stopped_q (stopped),
        .snap_q    (snap)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_SYS;
        else if (mode_we)
            mode_q <= mode_e'(wdata[0]);
    end

    always_comb begin
        unique case (sel)
            SEL_LIMIT:  rd_mux = user_on ? {1'b0, snap} : {1'b0, limit_q};
            SEL_COUNT:  rd_mux = user_on ? {1'b0, acc[CNT_W-1:0], {SHIFT{1'b0}}}
                                         : {reached, sys_count, {SHIFT{1'b0}}};
            SEL_RUNCTL: rd_mux = {31'd0, stopped};
            SEL_MODE:   rd_mux = {31'd0, mode_q};
            default:    rd_mux = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;
    assign irq   = reached && !user_on;

endmodule

// File: rtl/cmp_timer_checker.sv
module cmp_timer_checker #(
    parameter int SHIFT        = 9,
    parameter int CNT_W        = 22,
    parameter int USER_W       = 54,
    parameter bit FIXED_SYSTEM = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [2:0]        sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic              wbit0,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic              mode,
    input logic [CNT_W-1:0]  count,
    input logic              reached,
    input logic              stopped,
    input logic [USER_W-1:0] acc
);

    logic sys_ack;
    assign sys_ack = rd_en && (sel == 3'd0) && !mode;

    // R6: acknowledge clears flag, interrupt and count
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        sys_ack |=> (!irq && !reached && count == '0));

    // R5: limit write at offset 0 restarts the count
    p_restart_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == 3'd0) |=> (count == '0));

    // R7: reached flag holds until acknowledged
    p_reached_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (reached && !sys_ack) |=> reached);

    // R4: system count either steps by one or wraps to zero
    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!mode && tick) |=> (count == $past(count) + 1'b1 || count == '0));

    // R10: system count frozen in user mode
    p_sys_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (mode && !(wr_en && sel == 3'd0)) |=> ($stable(count) && $stable(reached)));

    // R10: no interrupt in user mode
    p_user_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        mode |-> !irq);

    // R9: stopped accumulator does not move
    p_acc_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        stopped |=> $stable(acc));

    // R8: running user accumulator steps per tick
    p_acc_step_r8: assert property (@(posedge clk) disable iff (rst)
        (mode && !stopped && tick) |=> (acc == $past(acc) + 1'b1));

    // R3: low field of a count read is zero
    p_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == 3'd1) |=> (rdata[SHIFT-1:0] == '0));

    // R11: mode write honoured only on switchable instances
    p_mode_write_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == 3'd4) |=> (mode == (FIXED_SYSTEM ? 1'b0 : $past(wbit0))));

endmodule

bind cmp_timer cmp_timer_checker #(
    .SHIFT(SHIFT), .CNT_W(CNT_W), .USER_W(USER_W), .FIXED_SYSTEM(FIXED_SYSTEM)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .sel     (reg_addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wbit0   (wdata[0]),
    .rdata   (rdata),
    .irq     (irq),
    .mode    (mode_q),
    .count   (sys_count),
    .reached (reached),
    .stopped (stopped),
    .acc     (acc)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata, rdata_f;
    logic        irq, irq_f;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] rv, rvf;

    always #10 clk = ~clk;

    cmp_timer #(.SHIFT(27), .FIXED_SYSTEM(1'b0)) i_cmp_timer (
        .clk(clk), .rst(rst), .tick(tick), .reg_addr(reg_addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    cmp_timer #(.SHIFT(27), .FIXED_SYSTEM(1'b1)) i_cmp_timer_fixed (
        .clk(clk), .rst(rst), .tick(tick), .reg_addr(reg_addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata_f), .irq(irq_f)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_addr = off; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] off);
        @(negedge clk);
        reg_addr = off; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        rv = rdata; rvf = rdata_f;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R1 irq", {31'd0, irq}, 32'd0);
        bus_read(3'd1); check("R1 count", rv, 32'h0);
        bus_read(3'd3); check("R1 stopped", rv, 32'h1);
        bus_read(3'd4); check("R1 mode", rv, 32'h0);
        bus_read(3'd0); check("R1 limit", rv, 32'h0);
    endtask

    task automatic t_limit_fix;
        bus_write(3'd2, 32'h0);
        bus_read(3'd0); check("R2 zero limit", rv, 32'h7FFF_FFFF);
        bus_write(3'd2, 32'hA800_0001);
        bus_read(3'd0); check("R2 bit31 dropped", rv, 32'h2800_0001);
    endtask

    task automatic t_wrap;
        bus_write(3'd0, 32'h1800_0000);
        ticks(2);
        bus_read(3'd1); check("R3 count two", rv, 32'h1000_0000);
        check("R4 no irq yet", {31'd0, irq}, 32'd0);
        ticks(1);
        bus_read(3'd1); check("R4 wrap reached", rv, 32'h8000_0000);
        check("R4 irq set", {31'd0, irq}, 32'd1);
        ticks(1);
        bus_read(3'd1); check("R7 sticky", rv, 32'h8800_0000);
        check("R7 irq held", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_ack;
        bus_read(3'd0); check("R6 ack returns limit", rv, 32'h1800_0000);
        check("R6 irq cleared", {31'd0, irq}, 32'd0);
        bus_read(3'd1); check("R6 count restarted", rv, 32'h0);
        ticks(2);
        check("R13 rdata held", rdata, 32'h0);
    endtask

    task automatic t_rewrite;
        bus_write(3'd2, 32'h2800_0000);
        bus_read(3'd1); check("R5 offset2 keeps count", rv, 32'h1000_0000);
        bus_write(3'd0, 32'h2800_0000);
        bus_read(3'd1); check("R5 offset0 restarts", rv, 32'h0);
        ticks(4);
        bus_read(3'd1); check("R4 below period", rv, 32'h2000_0000);
        bus_write(3'd2, 32'h1000_0000);
        ticks(1);
        bus_read(3'd1); check("R4 shrink wraps", rv, 32'h8000_0000);
        bus_read(3'd0); check("R6 ack", rv, 32'h1000_0000);
    endtask

    task automatic t_full_period;
        bus_write(3'd0, 32'h0000_0100);
        ticks(15);
        bus_read(3'd1); check("R4 full period top", rv, 32'h7800_0000);
        check("R4 no irq at top", {31'd0, irq}, 32'd0);
        ticks(1);
        bus_read(3'd1); check("R4 full period wrap", rv, 32'h8000_0000);
        check("R4 irq full period", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_user;
        bus_write(3'd4, 32'h1);
        check("R10 irq low in user", {31'd0, irq}, 32'd0);
        bus_read(3'd4); check("R11 mode user", rv, 32'h1);
        check("R11 fixed stays system", rvf, 32'h0);
        bus_read(3'd3); check("R9 initially stopped", rv, 32'h1);
        ticks(3);
        bus_read(3'd1); check("R9 stopped no count", rv, 32'h0);
        bus_write(3'd3, 32'h0);
        bus_read(3'd3); check("R9 running", rv, 32'h0);
        ticks(18);
        bus_read(3'd1); check("R8 low word", rv, 32'h1000_0000);
        bus_read(3'd0); check("R8 high word", rv, 32'h1);
        check("R10 irq still low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_stop;
        bus_write(3'd3, 32'h1);
        ticks(5);
        bus_read(3'd1); check("R9 frozen", rv, 32'h1000_0000);
        bus_read(3'd3); check("R9 status stopped", rv, 32'h1);
        bus_write(3'd3, 32'h0);
        ticks(1);
        bus_read(3'd1); check("R9 resumed", rv, 32'h1800_0000);
    endtask

    task automatic t_snapshot;
        ticks(13);
        bus_read(3'd0); check("R8 snapshot kept", rv, 32'h1);
        bus_read(3'd1); check("R8 low after carry", rv, 32'h0);
        bus_read(3'd0); check("R8 snapshot updated", rv, 32'h2);
    endtask

    task automatic t_back_to_sys;
        bus_write(3'd4, 32'h0);
        check("R10 irq returns", {31'd0, irq}, 32'd1);
        bus_read(3'd1); check("R10 count held", rv, 32'h8000_0000);
        bus_write(3'd3, 32'h1);
        bus_read(3'd3); check("R9 runctl ignored in system", rv, 32'h0);
        bus_read(3'd0); check("R6 final ack", rv, 32'h0000_0100);
        check("R6 irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_unused;
        bus_write(3'd5, 32'hFFFF_FFFF);
        bus_write(3'd6, 32'hFFFF_FFFF);
        bus_write(3'd7, 32'h0000_0001);
        bus_read(3'd0); check("R12 limit untouched", rv, 32'h0000_0100);
        bus_read(3'd4); check("R12 mode untouched", rv, 32'h0);
        bus_read(3'd2); check("R12 offset2 reads zero", rv, 32'h0);
        bus_read(3'd5); check("R12 offset5 reads zero", rv, 32'h0);
        bus_read(3'd7); check("R12 offset7 reads zero", rv, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_limit_fix();
        t_wrap();
        t_ack();
        t_rewrite();
        t_full_period();
        t_user();
        t_stop();
        t_snapshot();
        t_back_to_sys();
        t_unused();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule